// File: doc/BRIEF.md
# Four-Step-Per-Cycle CORDIC Core

This block is an iterative fixed-point CORDIC engine. It retires four micro-rotations in every clock cycle. A start pulse loads the operands and selects one of two modes. In rotation mode the core turns an angle that has already been reduced into its cosine and sine. In vectoring mode it turns a vector (x, y) into its angle atan(y/x), added to a z offset, and into its scaled magnitude. Range reduction and any floating-point unpacking or packing are left to neighbouring logic.

The four steps of one cycle are not evaluated one after another. All sixteen combinations of their four rotation directions are evaluated side by side. Each combination checks whether the signs it produced agree with the directions it assumed, and the one combination that agrees supplies the next state. The only operations are arithmetic shifts, additions and subtractions, plus a constant table of atan(2^-i). That table and the inverse CORDIC gain are computed when the design is elaborated. The datapath width W is a parameter, and the core runs W micro-rotations in ceil(W/4) cycles. The default is 16 bits. Widths up to about 140 bits are supported, which covers a precision near 113 bits. A few guard bits below the interface LSB absorb the truncation of the shifts.

Top module: `cordic4_core`

## Requirements
- R1: In rotation mode (mode = 0), for an input angle z_in with |z_in| <= pi/2, x_out equals cos(z_in) and y_out equals sin(z_in), each within 4 LSB. All data ports are two's-complement with W-2 fraction bits, so the LSB is 2^-(W-2).
- R2: Each busy cycle with group index k applies the micro-rotations with shifts 4k, 4k+1, 4k+2 and 4k+3. Of the sixteen speculative direction branches, exactly one is consistent with the signs it produces.
- R3: In vectoring mode (mode = 1), for x_in > 0, z_out equals z_in + atan(y_in/x_in) within 6 LSB. x_out equals Kw·sqrt(x_in²+y_in²) within 6 LSB, where Kw is the product of sqrt(1+2^-2i) for i = 0..W-1. y_out is within 6 LSB of zero.
- R4: done rises exactly ceil(W/4) cycles after the clock edge that accepts start. This is 4 cycles at W = 16.
- R5: done is high for exactly one cycle per operation.
- R6: The results are valid in the done cycle. They stay unchanged, whatever the inputs do, until the next accepted start.
- R7: A start pulse while an operation is in progress is ignored. It changes neither the result nor the completion time of the running operation.
- R8: In rotation mode the values on x_in and y_in have no effect on the result.
- R9: After reset, done is low and x_out, y_out and z_out are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; sampled only while idle |
| mode | input | 1 | 0 = rotation (cos/sin), 1 = vectoring (atan) |
| x_in | input | W | Vector x component (vectoring only) |
| y_in | input | W | Vector y component (vectoring only) |
| z_in | input | W | Angle (rotation) or angle offset (vectoring) |
| done | output | 1 | One-cycle pulse when the results are ready |
| x_out | output | W | cos(z) or scaled magnitude |
| y_out | output | W | sin(z) or residual y |
| z_out | output | W | Residual angle or accumulated arctangent |

## Verification
On every busy cycle, the assertions check that exactly one of the sixteen speculative branches is consistent. They also check that the group index advances by one and is never restarted by a start, that done lasts a single cycle and only ends a busy period, and that results hold while the core is idle. Only the bench's scenarios can show the numerical behaviour. These scenarios are sweeps of angles across the full ±pi/2 range and sweeps of vector angles at two magnitudes, with the results compared against real-valued cos, sin and atan2 and against the CORDIC gain. The scenarios also measure the completion latency, show that a start pulse during a run changes neither the outcome nor the latency, and show that junk on x_in and y_in leaves rotation results unchanged.

// File: rtl/cordic4_pkg.sv
package cordic4_pkg;

    // Constant-generation precision: CW-bit words scaled by 2^SB.
    localparam int CW = 160;
    localparam int SB = 150;

    typedef enum logic {
        MODE_ROT = 1'b0,
        MODE_VEC = 1'b1
    } cordic_mode_e;

    // atan(1/n) scaled by 2^SB, Taylor series, n > 1.
    function automatic logic [CW-1:0] atan_recip(input int unsigned n);
        logic [CW-1:0] one, p, t, s, nn;
        one = '0;
        one[SB] = 1'b1;
        nn = CW'(n * n);
        p = one / CW'(n);
        s = '0;
        for (int k = 0; k < 120; k++) begin
            if (p != '0) begin
                t = p / CW'(2 * k + 1);
                if ((k % 2) == 0) s = s + t;
                else              s = s - t;
                p = p / nn;
            end
        end
        return s;
    endfunction

    // atan(2^-i) scaled by 2^SB.
    function automatic logic [CW-1:0] atan_pow2(input int i);
        logic [CW-1:0] one, p, t, s;
        one = '0;
        one[SB] = 1'b1;
        s = '0;
        if (i == 0) begin
            s = (atan_recip(5) << 2) - atan_recip(239);
        end else begin
            p = one >> i;
            for (int k = 0; k < 120; k++) begin
                if (p != '0) begin
                    t = p / CW'(2 * k + 1);
                    if ((k % 2) == 0) s = s + t;
                    else              s = s - t;
                    p = p >> (2 * i);
                end
            end
        end
        return s;
    endfunction

    // Round a 2^SB-scaled value to fb fraction bits.
    function automatic logic [CW-1:0] to_fixed(input logic [CW-1:0] v, input int fb);
        logic [CW-1:0] one, r;
        one = '0;
        one[SB] = 1'b1;
        r = v + (one >> (fb + 1));
        return r >> (SB - fb);
    endfunction

    // 1 / prod(sqrt(1 + 2^-2i)), i = 0..n-1, scaled by 2^SB.
    function automatic logic [CW-1:0] inv_gain(input int n);
        logic [CW-1:0]   one, k2;
        logic [2*CW-1:0] num, sq, res, bitv;
        one = '0;
        one[SB] = 1'b1;
        k2 = one;
        for (int i = 0; i < n; i++) k2 = k2 + (k2 >> (2 * i));
        num = '0;
        num[2*SB] = 1'b1;
        sq = (num / {{CW{1'b0}}, k2}) << SB;
        res = '0;
        bitv = '0;
        bitv[2*CW-2] = 1'b1;
        for (int s = 0; s < CW; s++) begin
            if (sq >= res + bitv) begin
                sq  = sq - (res + bitv);
                res = (res >> 1) + bitv;
            end else begin
                res = res >> 1;
            end
            bitv = bitv >> 2;
        end
        return res[CW-1:0];
    endfunction

endpackage

// File: rtl/cordic4_step.sv
module cordic4_step #(
    parameter int IW  = 20,
    parameter int SHW = 4
) (
    input  logic signed [IW-1:0]  x_i,
    input  logic signed [IW-1:0]  y_i,
    input  logic signed [IW-1:0]  z_i,
    input  logic        [SHW-1:0] sh_i,
    input  logic signed [IW-1:0]  ang_i,
    input  logic                  pos_i,
    input  logic                  en_i,
    output logic signed [IW-1:0]  x_o,
    output logic signed [IW-1:0]  y_o,
    output logic signed [IW-1:0]  z_o
);

    logic signed [IW-1:0] xs, ys;

    always_comb begin
        xs = x_i >>> sh_i;
        ys = y_i >>> sh_i;
        x_o = x_i;
        y_o = y_i;
        z_o = z_i;
        if (en_i) begin
            if (pos_i) begin
                x_o = x_i - ys;
                y_o = y_i + xs;
                z_o = z_i - ang_i;
            end else begin
                x_o = x_i + ys;
                y_o = y_i - xs;
                z_o = z_i + ang_i;
            end
        end
    end

endmodule

// File: rtl/cordic4_group.sv
module cordic4_group
    import cordic4_pkg::*;
#(
    parameter int IW    = 20,
    parameter int NITER = 16,
    parameter int GW    = 2,
    localparam int SHW  = GW + 2,
    localparam int NBR  = 16
) (
    input  cordic_mode_e          mode_i,
    input  logic [GW-1:0]         grp_i,
    input  logic signed [IW-1:0]  x_i,
    input  logic signed [IW-1:0]  y_i,
    input  logic signed [IW-1:0]  z_i,
    input  logic signed [IW-1:0]  ang_i [4],
    output logic signed [IW-1:0]  x_o,
    output logic signed [IW-1:0]  y_o,
    output logic signed [IW-1:0]  z_o,
    output logic [NBR-1:0]        match_o
);

    logic signed [IW-1:0] fx [NBR];
    logic signed [IW-1:0] fy [NBR];
    logic signed [IW-1:0] fz [NBR];

    for (genvar b = 0; b < NBR; b++) begin : g_br
        logic signed [IW-1:0] cx [5];
        logic signed [IW-1:0] cy [5];
        logic signed [IW-1:0] cz [5];
        logic [3:0]           ok;

        assign cx[0] = x_i;
        assign cy[0] = y_i;
        assign cz[0] = z_i;

        for (genvar j = 0; j < 4; j++) begin : g_st
            localparam logic DIRP = (((b >> j) & 1) == 1);
            logic [SHW-1:0] sh;
            logic           en;
            logic           want;

            assign sh   = {grp_i, 2'(j)};
            assign en   = int'(sh) < NITER;
            assign want = (mode_i == MODE_VEC) ? cy[j][IW-1] : !cz[j][IW-1];
            assign ok[j] = en ? (want == DIRP) : !DIRP;

            cordic4_step #(.IW(IW), .SHW(SHW)) u_step (
                .x_i  (cx[j]),
                .y_i  (cy[j]),
                .z_i  (cz[j]),
                .sh_i (sh),
                .ang_i(ang_i[j]),
                .pos_i(DIRP),
                .en_i (en),
                .x_o  (cx[j+1]),
                .y_o  (cy[j+1]),
                .z_o  (cz[j+1])
            );
        end

        assign match_o[b] = &ok;
        assign fx[b] = cx[4];
        assign fy[b] = cy[4];
        assign fz[b] = cz[4];
    end

    always_comb begin
        x_o = '0;
        y_o = '0;
        z_o = '0;
        for (int b = 0; b < NBR; b++) begin
            x_o = x_o | (fx[b] & {IW{match_o[b]}});
            y_o = y_o | (fy[b] & {IW{match_o[b]}});
            z_o = z_o | (fz[b] & {IW{match_o[b]}});
        end
    end

endmodule

// File: rtl/cordic4_core.sv
module cordic4_core
    import cordic4_pkg::*;
#(
    parameter int W = 16,
    parameter int G = 4,
    localparam int IW    = W + G,
    localparam int FB    = W - 2 + G,
    localparam int NITER = W,
    localparam int NGRP  = (NITER + 3) / 4,
    localparam int NSTEP = NGRP * 4,
    localparam int GW    = (NGRP > 1) ? $clog2(NGRP) : 1,
    localparam int SHW   = GW + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                mode,
    input  logic signed [W-1:0] x_in,
    input  logic signed [W-1:0] y_in,
    input  logic signed [W-1:0] z_in,
    output logic                done,
    output logic signed [W-1:0] x_out,
    output logic signed [W-1:0] y_out,
    output logic signed [W-1:0] z_out
);

    localparam logic [IW-1:0] INV_K = IW'(to_fixed(inv_gain(NITER), FB));
    localparam logic [GW-1:0] LAST  = GW'(NGRP - 1);
    localparam logic signed [IW-1:0] RND = IW'(1) <<< (G - 1);

    typedef struct packed {
        logic                 busy;
        logic                 done;
        cordic_mode_e         mode;
        logic [GW-1:0]        grp;
        logic signed [IW-1:0] x;
        logic signed [IW-1:0] y;
        logic signed [IW-1:0] z;
    } state_t;

    state_t state_d, state_q;

    // Arctangent constants, one per micro-rotation index.
    logic signed [IW-1:0] atan_tab [NSTEP];
    for (genvar t = 0; t < NSTEP; t++) begin : g_tab
        localparam logic [CW-1:0] RAD = atan_pow2(t);
        assign atan_tab[t] = IW'(to_fixed(RAD, FB));
    end

    logic signed [IW-1:0] ang_slice [4];
    logic signed [IW-1:0] gx, gy, gz;
    logic [15:0]          br_match;

    always_comb begin
        for (int j = 0; j < 4; j++) begin
            ang_slice[j] = atan_tab[{state_q.grp, 2'(j)}];
        end
    end

    cordic4_group #(.IW(IW), .NITER(NITER), .GW(GW)) u_group (
        .mode_i (state_q.mode),
        .grp_i  (state_q.grp),
        .x_i    (state_q.x),
        .y_i    (state_q.y),
        .z_i    (state_q.z),
        .ang_i  (ang_slice),
        .x_o    (gx),
        .y_o    (gy),
        .z_o    (gz),
        .match_o(br_match)
    );

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        if (!state_q.busy) begin
            if (start) begin
                state_d.busy = 1'b1;
                state_d.grp  = '0;
                state_d.mode = cordic_mode_e'(mode);
                state_d.z    = {z_in, {G{1'b0}}};
                if (cordic_mode_e'(mode) == MODE_VEC) begin
                    state_d.x = {x_in, {G{1'b0}}};
                    state_d.y = {y_in, {G{1'b0}}};
                end else begin
                    state_d.x = INV_K;
                    state_d.y = '0;
                end
            end
        end else begin
            state_d.x = gx;
            state_d.y = gy;
            state_d.z = gz;
            if (state_q.grp == LAST) begin
                state_d.busy = 1'b0;
                state_d.done = 1'b1;
            end else begin
                state_d.grp = state_q.grp + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign done  = state_q.done;
    assign x_out = W'((state_q.x + RND) >>> G);
    assign y_out = W'((state_q.y + RND) >>> G);
    assign z_out = W'((state_q.z + RND) >>> G);

    // R2: exactly one speculative branch agrees with its own signs.
    assert_one_branch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.busy |-> $onehot(br_match));

    // R7: while running, the group index only advances; start cannot restart it.
    assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.busy && (state_q.grp != LAST)) |=> (state_q.grp == $past(state_q.grp) + 1'b1));

    // R5: done lasts one cycle.
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: done only closes a busy period.
    assert_done_after_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(state_q.busy) && !state_q.busy));

    // R6: idle without start keeps results.
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!state_q.busy && !start) |=> ($stable(x_out) && $stable(y_out) && $stable(z_out)));

endmodule

// File: tb/cordic4_core_tb.sv
`timescale 1ns/1ps
module cordic4_core_tb;

    localparam int  W   = 16;
    localparam int  NC  = (W + 3) / 4;
    localparam real SC  = 16384.0;
    localparam real LSB = 1.0 / 16384.0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic mode = 1'b0;
    logic signed [W-1:0] x_in = '0, y_in = '0, z_in = '0;
    logic done;
    logic signed [W-1:0] x_out, y_out, z_out;

    int  n_cmp = 0;
    int  n_bad = 0;
    int  lat;
    bit  finished = 1'b0;
    real kg;

    cordic4_core #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .x_in(x_in), .y_in(y_in), .z_in(z_in),
        .done(done), .x_out(x_out), .y_out(y_out), .z_out(z_out)
    );

    always #2.5 clk = ~clk;

    function automatic logic signed [W-1:0] qf(input real v);
        return W'($rtoi(v * SC + ((v >= 0.0) ? 0.5 : -0.5)));
    endfunction

    function automatic real rf(input logic signed [W-1:0] v);
        return $itor(v) / SC;
    endfunction

    task automatic chk_r(input string tag, input real act, input real exp, input real tol);
        n_cmp++;
        if ((act - exp > tol * LSB) || (exp - act > tol * LSB)) begin
            n_bad++;
            $display("FAIL %s: actual %f expected %f", tag, act, exp);
        end
    endtask

    task automatic chk_i(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_done();
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic op(input logic m, input logic signed [W-1:0] xv,
                      input logic signed [W-1:0] yv, input logic signed [W-1:0] zv);
        @(negedge clk);
        mode = m; x_in = xv; y_in = yv; z_in = zv; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        wait_done();
    endtask

    task automatic rot_check(input real z, input logic signed [W-1:0] jx,
                             input logic signed [W-1:0] jy, input string tag);
        real zr;
        zr = rf(qf(z));
        op(1'b0, jx, jy, qf(z));
        chk_i("R4 latency", lat, NC + 1);
        chk_r({tag, " cos"}, rf(x_out), $cos(zr), 4.0);
        chk_r({tag, " sin"}, rf(y_out), $sin(zr), 4.0);
    endtask

    task automatic vec_check(input real xv, input real yv, input real z0);
        real xr, yr, zr;
        xr = rf(qf(xv)); yr = rf(qf(yv)); zr = rf(qf(z0));
        op(1'b1, qf(xv), qf(yv), qf(z0));
        chk_i("R4 latency", lat, NC + 1);
        chk_r("R3 angle", rf(z_out), zr + $atan2(yr, xr), 6.0);
        chk_r("R3 magnitude", rf(x_out), kg * $sqrt(xr * xr + yr * yr), 6.0);
        chk_r("R3 residual y", rf(y_out), 0.0, 6.0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        real p;
        real sx, sy, sz;
        kg = 1.0;
        p = 1.0;
        for (int i = 0; i < W; i++) begin
            kg = kg * $sqrt(1.0 + p * p);
            p = p / 2.0;
        end

        repeat (4) @(negedge clk);
        chk_i("R9 done at reset", int'(done), 0);
        chk_i("R9 x_out at reset", int'(x_out), 0);
        chk_i("R9 y_out at reset", int'(y_out), 0);
        chk_i("R9 z_out at reset", int'(z_out), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk_i("R9 done idle", int'(done), 0);

        // R1: sweep across the full angle range, including both ends.
        for (int i = 0; i <= 256; i++) begin
            rot_check(-1.5707 + 3.1414 * $itor(i) / 256.0, '0, '0, "R1");
        end
        rot_check(0.0, '0, '0, "R1 zero");

        // R8: junk on x_in / y_in must not matter in rotation mode.
        for (int i = 0; i < 16; i++) begin
            rot_check(-1.2 + 0.16 * $itor(i), W'(i * 4099 + 123), W'(i * 7919 + 55), "R8");
        end

        // R3: vector angles at two magnitudes.
        for (int i = 0; i <= 64; i++) begin
            real a;
            a = -1.4 + 2.8 * $itor(i) / 64.0;
            vec_check(0.4 * $cos(a), 0.4 * $sin(a), 0.0);
            vec_check(0.75 * $cos(a), 0.75 * $sin(a), 0.0);
        end
        vec_check(0.9, 0.0, 0.0);
        vec_check(0.6 * $cos(0.3), 0.6 * $sin(0.3), 0.5);

        // R5: done falls after one cycle.
        rot_check(0.7, '0, '0, "R1");
        @(negedge clk);
        chk_i("R5 done one cycle", int'(done), 0);

        // R6: results hold while idle with changing inputs.
        sx = rf(x_out); sy = rf(y_out); sz = rf(z_out);
        mode = 1'b1; x_in = qf(0.3); y_in = qf(-0.5); z_in = qf(1.0);
        repeat (3) @(negedge clk);
        chk_r("R6 hold x", rf(x_out), sx, 0.0);
        chk_r("R6 hold y", rf(y_out), sy, 0.0);
        chk_r("R6 hold z", rf(z_out), sz, 0.0);

        // R7: a second start during the run is ignored.
        @(negedge clk);
        mode = 1'b0; z_in = qf(0.6); start = 1'b1;
        @(negedge clk);
        start = 1'b0; lat = 1;
        @(negedge clk);
        lat = 2;
        mode = 1'b1; x_in = qf(0.5); y_in = qf(0.5); z_in = qf(-1.0); start = 1'b1;
        @(negedge clk);
        start = 1'b0; lat = 3;
        wait_done();
        chk_i("R7 latency unchanged", lat, NC + 1);
        chk_r("R7 cos kept", rf(x_out), $cos(rf(qf(0.6))), 4.0);
        chk_r("R7 sin kept", rf(y_out), $sin(rf(qf(0.6))), 4.0);
        repeat (3) @(negedge clk);
        chk_i("R7 no second run", int'(done), 0);
        chk_r("R7 result still held", rf(y_out), $sin(rf(qf(0.6))), 4.0);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule